// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block holds the software-visible control state of one bus-master DMA channel for a disk controller. A host writes and reads it over a simple byte-addressed register bus. The block keeps a command byte, a status byte and a 32-bit base address for the descriptor table. It turns changes of the command's start bit into one-cycle control pulses for a separate descriptor walker, and it loads the walker's current-descriptor pointer from the table base.

The walker reports back through two inputs: one flags a bus error and one ends the transfer. The drive's interrupt request is passed straight through to the interrupt output. A rising edge of that request also latches a sticky status flag, which software clears by writing a one to it.

Register offsets: command at 0, status at 2, table base at 4 to 7. Reads are combinational. A read at offset 4 to 7 returns the base shifted right by 8 bits for each byte of the offset beyond 4. A write carries its data in the low bits of the write data, and its size is 0 for a byte, 1 for a halfword and 2 for a word.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the command, status, table base and current pointer read as zero, and the start, cancel and load pulses are low.
- R2: A write at offset 0 stores only data bits 0 (start) and 3 (direction). All other command bits read as zero, and `dir` follows bit 3.
- R3: A command write whose bit 0 equals the stored start bit issues no start, cancel or load pulse and leaves the active flag unchanged.
- R4: A command write that changes start from 1 to 0 raises `eng_cancel` for one cycle after the write and clears the active flag (status bit 0).
- R5: A command write that changes start from 0 to 1 raises `ptr_load` for one cycle and copies the table base into `cur_ptr`. If the active flag was clear, it also sets the active flag and raises `eng_start` for that cycle.
- R6: A status write at offset 2 stores data bits 6 and 5 as written and leaves bit 0 (active) as it was. For bit 1 (error) and bit 2 (interrupt), a written 1 clears the bit and a written 0 keeps it. Bits 4, 3 and 7 read as zero.
- R7: A write at offset 4 to 7 updates 1, 2 or 4 bytes (size 0, 1, 2). The bytes start at the lane given by offset minus 4, and bytes beyond offset 7 are dropped. Base bits 1:0 always store zero.
- R8: `irq_out` equals `drv_irq` in the same cycle. A rising edge of `drv_irq` sets status bit 2 one cycle later, and a falling edge leaves it set.
- R9: `eng_err` sets status bit 1 and wins over a same-cycle clear. `eng_done` clears the active flag, except that a same-cycle 0-to-1 start keeps it set.
- R10: A write to an unmapped offset (1, 3, 8 to 15) changes no register, and a read at such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Byte offset |
| reg_size | input | 2 | Write size: 0 byte, 1 halfword, 2 word |
| reg_wdata | input | 32 | Write data, low-aligned |
| reg_rdata | output | 32 | Read data for reg_addr |
| eng_err | input | 1 | Walker bus error |
| eng_done | input | 1 | Walker finished transfer |
| drv_irq | input | 1 | Drive interrupt request |
| irq_out | output | 1 | Interrupt to host |
| dir | output | 1 | Transfer direction (command bit 3) |
| active | output | 1 | Status active flag |
| eng_start | output | 1 | One-cycle start pulse to walker |
| eng_cancel | output | 1 | One-cycle cancel pulse to walker |
| ptr_load | output | 1 | One-cycle pointer-load pulse |
| cur_ptr | output | 32 | Current descriptor pointer |

## Verification
Register contents appear on `reg_rdata` in the cycle after the write edge. The bench drives on the falling edge and reads back at the next falling edge. The start, cancel and load pulses are registered, so they are high only during the cycle that follows the write edge. The bench samples them at the first falling edge after the write and again one cycle later to confirm they dropped. `irq_out` has no register in its path and is checked 1 ns after `drv_irq` changes. The latched status flags are checked one cycle after the edge that sets or clears them.

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [1:0]    reg_size,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          eng_err,
  input  logic          eng_done,
  input  logic          drv_irq,
  output logic          irq_out,
  output logic          dir,
  output logic          active,
  output logic          eng_start,
  output logic          eng_cancel,
  output logic          ptr_load,
  output logic [DW-1:0] cur_ptr
);
  localparam int NB = DW / 8;
  localparam logic [AW-1:0] OFF_CMD = AW'(0);
  localparam logic [AW-1:0] OFF_STS = AW'(2);
  localparam logic [AW-1:0] OFF_BASE = AW'(4);

  logic [7:0] cmd_q;
  logic sts_act, sts_err, sts_int;
  logic [1:0] sts_usr;
  logic [DW-1:0] base_q, cur_q;
  logic irq_prev, start_q, cancel_q, load_q;

  wire cmd_wr  = reg_wr && reg_addr == OFF_CMD;
  wire sts_wr  = reg_wr && reg_addr == OFF_STS;
  wire base_wr = reg_wr && reg_addr[AW-1:2] == OFF_BASE[AW-1:2];
  wire [1:0] lane = reg_addr[1:0];

  wire start_rise = cmd_wr && reg_wdata[0] && !cmd_q[0];
  wire start_fall = cmd_wr && !reg_wdata[0] && cmd_q[0];
  wire irq_rise   = drv_irq && !irq_prev;

  logic [NB-1:0] be;
  logic [DW-1:0] wshift, base_nx;
  always_comb begin
    case (reg_size)
      2'd0:    be = NB'(1);
      2'd1:    be = NB'(3);
      default: be = {NB{1'b1}};
    endcase
    be = be << lane;
    wshift = reg_wdata << {lane, 3'b000};
    base_nx = base_q;
    for (int i = 0; i < NB; i++)
      if (be[i]) base_nx[8*i +: 8] = wshift[8*i +: 8];
    base_nx[1:0] = 2'b00;
  end

  wire [7:0] sts_byte = {1'b0, sts_usr, 2'b00, sts_int, sts_err, sts_act};

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_CMD)      reg_rdata = DW'(cmd_q);
    else if (reg_addr == OFF_STS) reg_rdata = DW'(sts_byte);
    else if (reg_addr[AW-1:2] == OFF_BASE[AW-1:2])
      reg_rdata = base_q >> {lane, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; sts_act <= 1'b0; sts_err <= 1'b0; sts_int <= 1'b0;
      sts_usr <= '0; base_q <= '0; cur_q <= '0; irq_prev <= 1'b0;
      start_q <= 1'b0; cancel_q <= 1'b0; load_q <= 1'b0;
    end else begin
      irq_prev <= drv_irq;
      start_q  <= start_rise && !sts_act;
      cancel_q <= start_fall;
      load_q   <= start_rise;
      if (cmd_wr) cmd_q <= reg_wdata[7:0] & 8'h09;
      if (start_rise) cur_q <= base_q;
      if (base_wr) base_q <= base_nx;

      if (start_fall)      sts_act <= 1'b0;
      else if (start_rise) sts_act <= 1'b1;
      else if (eng_done)   sts_act <= 1'b0;

      if (sts_wr) sts_usr <= reg_wdata[6:5];
      sts_err <= eng_err  || (sts_err && !(sts_wr && reg_wdata[1]));
      sts_int <= irq_rise || (sts_int && !(sts_wr && reg_wdata[2]));
    end
  end

  assign irq_out    = drv_irq;
  assign dir        = cmd_q[3];
  assign active     = sts_act;
  assign eng_start  = start_q;
  assign eng_cancel = cancel_q;
  assign ptr_load   = load_q;
  assign cur_ptr    = cur_q;

  a_r3_same_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wdata[0] == cmd_q[0]) |=> (!eng_start && !eng_cancel && !ptr_load));
  a_r4_cancel_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cancel |-> !active);
  a_r4_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_start && eng_cancel));
  a_r5_start_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (ptr_load && active));
  a_r5_load_copies_base: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |-> cur_ptr == base_q);
  a_r8_irq_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_irq && !irq_prev) |=> sts_int);
  a_r9_err_latched: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> sts_err);
endmodule

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
  localparam int CLK_NS = 10;
  localparam int NV = 11;

  logic clk = 0, rst_n = 0, reg_wr = 0, eng_err = 0, eng_done = 0, drv_irq = 0;
  logic [3:0] reg_addr = 0;
  logic [1:0] reg_size = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, cur_ptr;
  logic irq_out, dir, active, eng_start, eng_cancel, ptr_load;
  int nchk = 0, nbad = 0;

  always #(CLK_NS/2) clk = ~clk;

  bmdma_regs uut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_size, .reg_wdata,
    .reg_rdata, .eng_err, .eng_done, .drv_irq, .irq_out, .dir, .active,
    .eng_start, .eng_cancel, .ptr_load, .cur_ptr);

  // {waddr, wsize, wdata, raddr, expected}
  localparam logic [73:0] VEC [NV] = '{
    {4'h4, 2'd2, 32'h12345677, 4'h4, 32'h12345674},  // R7 word, low bits forced 0
    {4'h5, 2'd0, 32'h000000AB, 4'h4, 32'h1234AB74},  // R7 byte lane 1
    {4'h6, 2'd1, 32'h0000BEEF, 4'h4, 32'hBEEFAB74},  // R7 half lanes 2-3
    {4'h4, 2'd0, 32'h000000FF, 4'h4, 32'hBEEFABFC},  // R7 byte lane 0
    {4'h7, 2'd1, 32'h00001122, 4'h6, 32'h000022EF},  // R7 drop past offset 7
    {4'h0, 2'd0, 32'h000000FE, 4'h0, 32'h00000008},  // R2 only bits 0,3
    {4'h2, 2'd0, 32'h000000FF, 4'h2, 32'h00000060},  // R6 bits 6:5 kept
    {4'h2, 2'd0, 32'h00000000, 4'h2, 32'h00000000},  // R6
    {4'h1, 2'd0, 32'h000000FF, 4'h0, 32'h00000008},  // R10 unmapped write
    {4'h3, 2'd0, 32'h000000FF, 4'h3, 32'h00000000},  // R10 unmapped read
    {4'h9, 2'd2, 32'hFFFFFFFF, 4'h4, 32'h22EFABFC}   // R10 base untouched
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_size = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    #(CLK_NS * 200000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, r); chk("R1 cmd", r, 0);
    rd(2, r); chk("R1 status", r, 0);
    rd(4, r); chk("R1 base", r, 0);
    chk("R1 cur_ptr", cur_ptr, 0);
    chk("R1 pulses", {eng_start, eng_cancel, ptr_load}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][73:70], VEC[i][69:68], VEC[i][67:36]);
      rd(VEC[i][35:32], r);
      chk($sformatf("vector %0d", i), r, VEC[i][31:0]);
    end
    chk("R2 dir", dir, 1);

    // R5 start from idle
    wr(0, 0, 32'h01);
    chk("R5 start/load/cancel", {eng_start, ptr_load, eng_cancel}, 3'b110);
    chk("R5 cur_ptr", cur_ptr, 32'h22EFABFC);
    chk("R5 active", active, 1);
    @(negedge clk);
    chk("R5 pulse one cycle", {eng_start, ptr_load}, 0);

    // R6 status write keeps active
    wr(2, 0, 32'h00);
    rd(2, r); chk("R6 active kept", r, 32'h01);

    // R3 same start bit, direction change
    wr(0, 0, 32'h09);
    chk("R3 no pulses", {eng_start, eng_cancel, ptr_load}, 0);
    rd(0, r); chk("R2 cmd 09", r, 32'h09);

    // R9 done clears active; R3 repeat start keeps it clear
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
    chk("R9 done clears active", active, 0);
    wr(0, 0, 32'h01);
    chk("R3 no restart", {eng_start, ptr_load, active}, 0);

    // R4 stop
    wr(0, 0, 32'h00);
    chk("R4 cancel", {eng_cancel, eng_start, active}, 3'b100);
    @(negedge clk);
    chk("R4 cancel one cycle", eng_cancel, 0);

    // R9 done same cycle as start: active stays
    @(negedge clk);
    reg_wr = 1; reg_addr = 0; reg_size = 0; reg_wdata = 32'h01; eng_done = 1;
    @(negedge clk);
    reg_wr = 0; eng_done = 0;
    chk("R9 start beats done", {active, eng_start}, 2'b11);
    wr(0, 0, 32'h00);

    // R9 error latch and W1C, and set beats clear
    @(negedge clk); eng_err = 1; @(negedge clk); eng_err = 0;
    rd(2, r); chk("R9 err set", r, 32'h02);
    wr(2, 0, 32'h00);
    rd(2, r); chk("R6 err kept on 0", r, 32'h02);
    wr(2, 0, 32'h02);
    rd(2, r); chk("R6 err W1C", r, 32'h00);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2; reg_wdata = 32'h02; eng_err = 1;
    @(negedge clk);
    reg_wr = 0; eng_err = 0;
    rd(2, r); chk("R9 set beats clear", r, 32'h02);
    wr(2, 0, 32'h02);

    // R8 interrupt
    @(negedge clk); drv_irq = 1; #1;
    chk("R8 pass high", irq_out, 1);
    @(negedge clk);
    rd(2, r); chk("R8 int set", r, 32'h04);
    drv_irq = 0; #1;
    chk("R8 pass low", irq_out, 0);
    @(negedge clk);
    rd(2, r); chk("R8 int sticky", r, 32'h04);
    wr(2, 0, 32'h04);
    rd(2, r); chk("R6 int W1C", r, 32'h00);

    // R1 reset again clears everything
    wr(2, 0, 32'h60);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(2, r); chk("R1 status after reset", r, 0);
    rd(4, r); chk("R1 base after reset", r, 0);
    chk("R1 cur_ptr after reset", cur_ptr, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule